// File: doc/BRIEF.md
# Variable-Latency I/O Burst Sequencer

This block drives one chip-select region of an external static bus for slow peripherals whose access time is not fixed. A single request carries a start address, a direction, a beat count of one to four words, per-lane byte enables and up to four words of write data. The block then produces the address, chip select, byte-lane strobes, an output-enable or write-enable strobe, and a data bus with a separate drive-enable output. All timing is counted in cycles of the block clock (the CPU clock). The memory clock runs at half that rate, so one memory cycle is two clock cycles.

Three 4-bit timing fields shape each transfer. The access-width field (`cfg_first`) sets how long the strobe stays low. The beat-gap field (`cfg_next`) sets the high time between beats. The recovery field (`cfg_recov`) sets the quiet time after a transfer. The device stretches each beat by pulling `bus_rdy` low. Each beat returns one `rsp_valid` pulse, which carries captured data on reads, and the transfer ends with one `rsp_done` pulse.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold its fields steady until then. The response side has no back-pressure. `rsp_valid` and `rsp_done` are single-cycle pulses that the consumer must take when they occur, because the external bus cannot be paused.

Top module: `vlio_burst_seq`

## Requirements
- R1: The address is driven with the request's start address, and chip select is still deasserted, in the first cycle after acceptance. Chip select asserts (low) in the next cycle with the address unchanged.
- R2: On the first beat, the output-enable or write-enable strobe goes low exactly 4 cycles after chip select goes low, which is 5 cycles after the address became valid.
- R3: Each beat holds its strobe low for 2*(cfg_first+1) cycles plus 2 cycles for every low sample of `bus_rdy`. Ready is sampled in the second-to-last cycle of the current low window. Reads use `bus_oe_n` only and writes use `bus_we_n` only.
- R4: Between beats the strobe is high for exactly 2*(cfg_next+1) cycles. The address, and on writes the data word, move to the next beat after the first of those high cycles.
- R5: `req_len` holds the beat count minus one (0 to 3). Beat b uses address A0+4*b, and on writes it uses data word b, taken from `req_wdata[32*b+31:32*b]`.
- R6: After the last beat the address stays unchanged in the first high-strobe cycle. Chip select stays asserted for exactly 2 cycles after the last strobe rises.
- R7: After chip select deasserts, `req_ready` stays low for exactly max(4*cfg_recov, 2) cycles.
- R8: After a write, `bus_dq_oe` stays high and `bus_dq_out` keeps the last word until the next transfer. On a read, drive is released (`bus_dq_oe` low) in the cycle where `bus_oe_n` first goes low, and never overlaps it.
- R9: `rsp_valid` pulses for one cycle in the first high-strobe cycle after each beat. On reads it carries `bus_dq_in` as sampled in the beat's last low cycle. `rsp_done` pulses once, in the cycle where chip select deasserts.
- R10: After reset, `req_ready`=1, all strobes are high, `bus_dq_oe`=0 and `rsp_valid`=0. A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. Request and timing inputs are latched at acceptance, so changing them later has no effect on the transfer. A request held valid while the block is busy is not accepted.
- R11: `bus_lane_n` equals the inverse of `req_be` while chip select is asserted, and is all ones otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and recovery finished |
| req_addr | input | 26 | Start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 2 | Beat count minus one |
| req_be | input | 4 | Byte lanes to enable |
| req_wdata | input | 128 | Write words, beat 0 in bits 31:0 |
| cfg_first | input | 4 | Access-width field |
| cfg_next | input | 4 | Beat-gap field |
| cfg_recov | input | 4 | Recovery field |
| bus_rdy | input | 1 | Device ready; low adds wait cycles |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_lane_n | output | 4 | Byte-lane strobes, active low |
| bus_addr | output | 26 | Bus address |
| bus_dq_out | output | 32 | Data driven toward the device |
| bus_dq_oe | output | 1 | Drive enable for bus_dq_out |
| bus_dq_in | input | 32 | Data returned by the device |
| rsp_valid | output | 1 | Beat completed pulse |
| rsp_data | output | 32 | Read data for the beat |
| rsp_done | output | 1 | Transfer completed pulse |

## Verification
The hardest situation to reach is a beat stretched by several ready-low samples on top of a long access width. The window is moved on each sample, so a ready value driven one cycle early or late silently changes the wait count. The bench computes, from the access-width field and the wanted wait count, the exact strobe cycles in which `bus_rdy` must be low. It drives `bus_rdy` cycle by cycle during each low strobe, then checks the measured width. Vectors also run a read straight after a write, to catch the drive hand-over. They change the timing inputs and hold a second request valid while a transfer is running, to show that latching and back-pressure hold.

// File: rtl/vlio_pkg.sv
package vlio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CES, ST_STRB, ST_GAP, ST_HOLD, ST_RECOV
  } seq_st_e;
  localparam int unsigned CES_CYCLES = 4;
endpackage

// File: rtl/vlio_seq_ctrl.sv
module vlio_seq_ctrl #(
  parameter int unsigned CFGW = 4,
  parameter int unsigned LENW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LENW-1:0]     req_len,
  input  logic [CFGW-1:0]     cfg_first,
  input  logic [CFGW-1:0]     cfg_next,
  input  logic [CFGW-1:0]     cfg_recov,
  input  logic                bus_rdy,
  output vlio_pkg::seq_st_e   st,
  output logic                accept,
  output logic                strobe_start,
  output logic                beat_end,
  output logic                advance,
  output logic                done_edge
);
  import vlio_pkg::*;
  localparam int unsigned CW = CFGW + 2;

  logic [CW-1:0]   cnt;
  logic [LENW-1:0] left;
  logic [CFGW-1:0] rdf_q, rdn_q, rrr_q;
  logic [CW-1:0]   strb_top, gap_top, rec_top;

  assign strb_top = CW'({rdf_q, 1'b1});
  assign gap_top  = CW'({rdn_q, 1'b1});
  assign rec_top  = (rrr_q == '0) ? CW'(1) : ({rrr_q, 2'b00} - CW'(1));

  assign req_ready    = (st == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign strobe_start = (st == ST_CES)  && (cnt == '0);
  assign beat_end     = (st == ST_STRB) && (cnt == '0);
  assign advance      = (st == ST_GAP)  && (cnt == gap_top);
  assign done_edge    = (st == ST_HOLD) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      left  <= '0;
      rdf_q <= '0;
      rdn_q <= '0;
      rrr_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st    <= ST_SETUP;
          left  <= req_len;
          rdf_q <= cfg_first;
          rdn_q <= cfg_next;
          rrr_q <= cfg_recov;
        end
        ST_SETUP: begin
          st  <= ST_CES;
          cnt <= CW'(CES_CYCLES - 1);
        end
        ST_CES: if (cnt == '0) begin
          st  <= ST_STRB;
          cnt <= strb_top;
        end else cnt <= cnt - 1'b1;
        ST_STRB: begin
          if (cnt == CW'(1) && !bus_rdy) cnt <= CW'(2);
          else if (cnt == '0) begin
            if (left != '0) begin
              st   <= ST_GAP;
              cnt  <= gap_top;
              left <= left - 1'b1;
            end else begin
              st  <= ST_HOLD;
              cnt <= CW'(1);
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_GAP: if (cnt == '0) begin
          st  <= ST_STRB;
          cnt <= strb_top;
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) begin
          st  <= ST_RECOV;
          cnt <= rec_top;
        end else cnt <= cnt - 1'b1;
        ST_RECOV: if (cnt == '0) st <= ST_IDLE;
                  else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // independent width monitor for the low strobe window
  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (st == ST_STRB) low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  AST_STRB_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |-> (int'(low_cnt) + 1 >= 2 * (int'(rdf_q) + 1))); // R3
endmodule

// File: rtl/vlio_addr_gen.sv
module vlio_addr_gen #(
  parameter int unsigned AW    = 26,
  parameter int unsigned LENW  = 2,
  parameter int unsigned LANES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            advance,
  input  logic [AW-1:0]   req_addr,
  output logic [AW-1:0]   bus_addr,
  output logic [LENW-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      idx      <= '0;
    end else if (accept) begin
      bus_addr <= req_addr;
      idx      <= '0;
    end else if (advance) begin
      bus_addr <= bus_addr + AW'(LANES);
      idx      <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/vlio_data_path.sv
module vlio_data_path #(
  parameter int unsigned DW    = 32,
  parameter int unsigned BEATS = 4,
  parameter int unsigned LENW  = 2,
  parameter int unsigned LANES = DW / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                req_write,
  input  logic [LANES-1:0]    req_be,
  input  logic [BEATS*DW-1:0] req_wdata,
  input  logic                advance,
  input  logic [LENW-1:0]     idx,
  input  logic                strobe_start,
  input  logic                beat_end,
  input  logic                done_edge,
  input  logic [DW-1:0]       bus_dq_in,
  output logic                write_q,
  output logic [LANES-1:0]    be_q,
  output logic [DW-1:0]       bus_dq_out,
  output logic                bus_dq_oe,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic                rsp_done
);
  logic [BEATS*DW-1:0] wbuf;
  logic [LENW-1:0]     nxt;
  assign nxt = idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf       <= '0;
      write_q    <= 1'b0;
      be_q       <= '0;
      bus_dq_out <= '0;
      bus_dq_oe  <= 1'b0;
    end else if (accept) begin
      wbuf    <= req_wdata;
      write_q <= req_write;
      be_q    <= req_be;
      if (req_write) begin
        bus_dq_out <= req_wdata[DW-1:0];
        bus_dq_oe  <= 1'b1;
      end
    end else begin
      if (advance && write_q) bus_dq_out <= wbuf[DW*int'(nxt) +: DW];
      if (strobe_start && !write_q) bus_dq_oe <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_valid <= beat_end;
      rsp_done  <= done_edge;
      if (beat_end && !write_q) rsp_data <= bus_dq_in;
    end
  end

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9
endmodule

// File: rtl/vlio_burst_seq.sv
module vlio_burst_seq #(
  parameter int unsigned AW    = 26,
  parameter int unsigned DW    = 32,
  parameter int unsigned BEATS = 4,
  parameter int unsigned CFGW  = 4,
  localparam int unsigned LANES = DW / 8,
  localparam int unsigned LENW  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_write,
  input  logic [LENW-1:0]     req_len,
  input  logic [LANES-1:0]    req_be,
  input  logic [BEATS*DW-1:0] req_wdata,
  input  logic [CFGW-1:0]     cfg_first,
  input  logic [CFGW-1:0]     cfg_next,
  input  logic [CFGW-1:0]     cfg_recov,
  input  logic                bus_rdy,
  output logic                bus_cs_n,
  output logic                bus_oe_n,
  output logic                bus_we_n,
  output logic [LANES-1:0]    bus_lane_n,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_dq_out,
  output logic                bus_dq_oe,
  input  logic [DW-1:0]       bus_dq_in,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_data,
  output logic                rsp_done
);
  import vlio_pkg::*;

  seq_st_e         st;
  logic            accept, strobe_start, beat_end, advance, done_edge;
  logic [LENW-1:0] idx;
  logic            write_q, cs_act, strb_n;
  logic [LANES-1:0] be_q;

  vlio_seq_ctrl #(.CFGW(CFGW), .LENW(LENW)) ctrl_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_len,
    .cfg_first, .cfg_next, .cfg_recov, .bus_rdy,
    .st, .accept, .strobe_start, .beat_end, .advance, .done_edge
  );

  vlio_addr_gen #(.AW(AW), .LENW(LENW), .LANES(LANES)) addr_i (
    .clk, .rst_n, .accept, .advance, .req_addr, .bus_addr, .idx
  );

  vlio_data_path #(.DW(DW), .BEATS(BEATS), .LENW(LENW), .LANES(LANES)) data_i (
    .clk, .rst_n, .accept, .req_write, .req_be, .req_wdata, .advance, .idx,
    .strobe_start, .beat_end, .done_edge, .bus_dq_in,
    .write_q, .be_q, .bus_dq_out, .bus_dq_oe, .rsp_valid, .rsp_data, .rsp_done
  );

  assign cs_act     = (st == ST_CES) || (st == ST_STRB) || (st == ST_GAP) || (st == ST_HOLD);
  assign bus_cs_n   = !cs_act;
  assign bus_oe_n   = !((st == ST_STRB) && !write_q);
  assign bus_we_n   = !((st == ST_STRB) && write_q);
  assign bus_lane_n = cs_act ? ~be_q : '1;
  assign strb_n     = bus_oe_n & bus_we_n;

  AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> $stable(bus_addr)); // R1
  AST_CS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> ##4 $fell(strb_n)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_n) |-> $stable(bus_addr)); // R6
  AST_RECOV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |=> !req_ready); // R7
  AST_DQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_dq_oe); // R8
endmodule

// File: tb/vlio_burst_seq_tb_top.sv
module vlio_burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 26, DW = 32, BEATS = 4, CFGW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, bus_rdy = 1'b1;
  logic [AW-1:0] req_addr = '0, bus_addr;
  logic [1:0] req_len = '0;
  logic [3:0] req_be = '0, bus_lane_n;
  logic [BEATS*DW-1:0] req_wdata = '0;
  logic [CFGW-1:0] cfg_first = '0, cfg_next = '0, cfg_recov = '0;
  logic bus_cs_n, bus_oe_n, bus_we_n, bus_dq_oe, rsp_valid, rsp_done;
  logic [DW-1:0] bus_dq_out, bus_dq_in, rsp_data;

  vlio_burst_seq #(.AW(AW), .DW(DW), .BEATS(BEATS), .CFGW(CFGW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write, .req_len,
    .req_be, .req_wdata, .cfg_first, .cfg_next, .cfg_recov, .bus_rdy,
    .bus_cs_n, .bus_oe_n, .bus_we_n, .bus_lane_n, .bus_addr, .bus_dq_out,
    .bus_dq_oe, .bus_dq_in, .rsp_valid, .rsp_data, .rsp_done
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_dq_in = 32'hA5C3_0000 ^ {6'd0, bus_addr};

  int checks = 0, fails = 0;
  bit prev_write = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wd(input logic [AW-1:0] a0, input int b);
    return 32'h5A00_0000 ^ (32'(b) * 32'h0101) ^ {6'd0, a0};
  endfunction
  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    return 32'hA5C3_0000 ^ {6'd0, a};
  endfunction

  typedef struct packed {
    logic       wr;
    logic [1:0] len;
    logic [3:0] be;
    logic [3:0] rdf, rdn, rrr;
    logic [1:0] waits;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 2'd3, 4'hF, 4'd2,  4'd1,  4'd0,  2'd0},
    '{1'b0, 2'd3, 4'hF, 4'd2,  4'd1,  4'd1,  2'd1},
    '{1'b0, 2'd0, 4'h3, 4'd0,  4'd0,  4'd0,  2'd2},
    '{1'b1, 2'd1, 4'hC, 4'd5,  4'd3,  4'd2,  2'd1},
    '{1'b0, 2'd2, 4'hF, 4'd1,  4'd0,  4'd3,  2'd0},
    '{1'b1, 2'd0, 4'h1, 4'd15, 4'd15, 4'd15, 2'd3}
  };

  task automatic do_xfer(input vec_t v, input logic [AW-1:0] a0);
    int nb = int'(v.len) + 1;
    int lw = 2 * (int'(v.rdf) + 1);
    int tcs = 0, s = 0, beat = 0, gap = 0, hold = 0, r = 0;
    bit prev_cs = 1'b1, prev_strb = 1'b1, strb, seen_done = 1'b0;
    @(negedge clk);
    req_addr = a0; req_write = v.wr; req_len = v.len; req_be = v.be;
    for (int b = 0; b < BEATS; b++) req_wdata[32*b +: 32] = wd(a0, b);
    cfg_first = v.rdf; cfg_next = v.rdn; cfg_recov = v.rrr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // keep a garbage request valid and scramble timing inputs (R10)
    req_addr = ~a0; req_len = ~v.len; req_write = ~v.wr;
    cfg_first = ~v.rdf; cfg_next = ~v.rdn; cfg_recov = ~v.rrr;
    chk(bus_cs_n && bus_addr == a0, "R1 addr before cs", {bus_cs_n, bus_addr}, {1'b1, a0});
    if (!v.wr) chk(bus_dq_oe == prev_write, "R8 drive kept until oe", bus_dq_oe, prev_write);
    for (int t = 1; t < 2000; t++) begin
      strb = bus_oe_n & bus_we_n;
      if (prev_cs && !bus_cs_n) begin
        tcs = t;
        chk(t == 2 && bus_addr == a0, "R1 cs one cycle after addr", t, 2);
      end
      if (!strb) begin
        if (prev_strb) begin
          if (beat == 0) chk(t - tcs == 4, "R2 cs to strobe", t - tcs, 4);
          else chk(gap == 2 * (int'(v.rdn) + 1), "R4 gap width", gap, 2 * (int'(v.rdn) + 1));
          chk(bus_addr == a0 + AW'(4 * beat), "R5 beat address", bus_addr, a0 + AW'(4 * beat));
          chk(bus_we_n == !v.wr && bus_oe_n == v.wr, "R3 strobe polarity", {bus_oe_n, bus_we_n}, {v.wr, !v.wr});
          if (v.wr) chk(bus_dq_oe && bus_dq_out == wd(a0, beat), "R4 write word", bus_dq_out, wd(a0, beat));
          else chk(!bus_dq_oe, "R8 released at oe", bus_dq_oe, 0);
          chk(bus_lane_n == ~v.be, "R11 lanes", bus_lane_n, ~v.be);
          s = 0;
        end
        bus_rdy = !(v.waits != 0 && s < lw + 2 * int'(v.waits) - 2);
        s++;
      end else begin
        bus_rdy = 1'b1;
        if (!prev_strb) begin
          chk(s == lw + 2 * int'(v.waits), "R3 strobe width", s, lw + 2 * int'(v.waits));
          chk(bus_addr == a0 + AW'(4 * beat), "R6 addr hold", bus_addr, a0 + AW'(4 * beat));
          chk(rsp_valid && (v.wr || rsp_data == rd(a0 + AW'(4 * beat))), "R9 beat response",
              rsp_data, rd(a0 + AW'(4 * beat)));
          beat++;
          gap = 0;
        end
        if (beat > 0 && beat < nb) gap++;
        if (beat == nb && !bus_cs_n) hold++;
      end
      if (!prev_cs && bus_cs_n) begin
        req_valid = 1'b0;
        chk(hold == 2, "R6 cs hold", hold, 2);
        chk(rsp_done, "R9 done pulse", rsp_done, 1);
        chk(beat == nb, "R10 beats from latched len", beat, nb);
        chk(bus_lane_n == 4'hF, "R11 lanes idle", bus_lane_n, 4'hF);
        if (v.wr) chk(bus_dq_oe && bus_dq_out == wd(a0, nb - 1), "R8 write data kept",
                      bus_dq_out, wd(a0, nb - 1));
        seen_done = 1'b1;
        break;
      end
      prev_cs = bus_cs_n;
      prev_strb = strb;
      @(negedge clk);
    end
    chk(seen_done, "R9 transfer completed", seen_done, 1);
    while (!req_ready && r < 200) begin
      r++;
      @(negedge clk);
    end
    chk(r == ((v.rrr == 0) ? 2 : 4 * int'(v.rrr)), "R7 recovery", r, (v.rrr == 0) ? 2 : 4 * int'(v.rrr));
    repeat (3) begin
      @(negedge clk);
      chk(bus_cs_n && req_ready, "R10 busy request ignored", {bus_cs_n, req_ready}, 2'b11);
    end
    prev_write = v.wr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_oe_n && bus_we_n && !bus_dq_oe && !rsp_valid && bus_lane_n == 4'hF,
        "R10 reset outputs", {bus_cs_n, bus_oe_n, bus_we_n, bus_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", req_ready, 1);
    repeat (4) begin
      @(negedge clk);
      chk(bus_cs_n && req_ready, "R10 no request no access", {bus_cs_n, req_ready}, 2'b11);
    end
    for (int i = 0; i < 6; i++) do_xfer(VECS[i], AW'(32'h1000 + 32'(i) * 32'h40));
    // directed: read right after write at the end of the address space corner
    do_xfer('{1'b1, 2'd1, 4'h6, 4'd0, 4'd0, 4'd0, 2'd1}, AW'(32'h3FF_FFF8));
    do_xfer('{1'b0, 2'd3, 4'h9, 4'd3, 4'd2, 4'd1, 2'd3}, AW'(32'h0000_0000));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule